// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Engine

This block is the device end of a three-wire serial nonvolatile memory, built as ordinary synchronous logic. A host raises the select line, clocks a start bit, a two-bit opcode, an address and, where the opcode needs it, a data word in on the serial input. The engine decodes the frame. It streams read data back on the serial output, or it schedules a programming operation into a 1K-bit storage array. An organization input chooses 16-bit words (64 of them) or 8-bit words (128 of them).

A write-enable latch protects the array. It is cleared at reset and must be set by a dedicated command before any write or erase takes effect. A programming operation starts when the select line falls. A parameterized tick counter then models the program time. During that time the output reports busy (low) and then ready (high) whenever the select line is high. The serial pins are oversampled by the system clock `clk`, so the serial clock must stay well below the system clock rate.

Top module: `eep_serial_slave`

## Requirements
- R1: With `cs` high, a rising edge of `sk` samples `di`. Zeros ahead of the first 1 are skipped. The 1 is the start bit, and it is followed by 2 opcode bits and then the address, sent MSB first. The address is 6 bits when `org`=1 (16-bit words) and 7 bits when `org`=0 (8-bit words).
- R2: Opcode 10 reads, 01 writes and 11 erases one word. With opcode 00, the top two address bits choose the command: 11 enables programming, 00 disables it, 10 erases every word and 01 writes one data word to every word. The other address bits are ignored.
- R3: After reset, programming is disabled. While it is disabled, write, erase, erase-all and write-all leave storage unchanged and start no busy period. The enable holds until a disable command or a reset.
- R4: Read works whatever the enable state. On the `sk` edge that takes the last address bit, `do_o` gives a 0 dummy bit. Each following `sk` rising edge gives the next data bit, MSB first. `do_o` changes one `clk` cycle after the synchronized `sk` rise.
- R5: While `cs` stays high, reading continues with the next address and no new address is sent. The address wraps from the last word (63, or 127 when `org`=0) to word 0.
- R6: Write and write-all take 16 data bits (`org`=1) or 8 data bits (`org`=0), MSB first, after the address. Programming begins on the falling edge of `cs`. When `org`=0, an even byte address selects bits 15:8 of 16-bit word (address>>1) and an odd byte address selects bits 7:0.
- R7: Erase and erase-all set the targeted cells to all ones. A write replaces the whole word without a prior erase.
- R8: For PROG_CYCLES `clk` cycles after programming begins, `do_o` is 0 while `cs` is high. After that period it is 1 while `cs` is high, until `cs` goes low.
- R9: `do_oe` is 0 whenever `cs` is low, and it is 0 after reset.
- R10: New frames are ignored while busy, and until `cs` has gone low once after ready.
- R11: A frame that `cs` ends before all its address and data bits have arrived changes nothing and starts no busy period.
- R12: Reset sets every storage cell to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock that oversamples the serial pins |
| rst_n | input | 1 | active-low asynchronous reset |
| cs | input | 1 | chip select, active high |
| sk | input | 1 | serial clock from the host |
| di | input | 1 | serial data in |
| org | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| do_o | output | 1 | serial data out / busy-ready value |
| do_oe | output | 1 | output enable for `do_o`; 0 means high impedance |

## Verification
Inputs pass through one synchronizer flop and one edge-detect flop, so a read bit appears on `do_o` two `clk` edges after `sk` is raised. The bench holds each `sk` level for two `clk` periods and samples `do_o` just before lowering `sk`, once that update is settled. Programming starts two `clk` edges after `cs` drops. The bench therefore checks busy two cycles after raising `cs` again, and checks ready well after the PROG_CYCLES window has passed. A scoreboard queue holds the expected dummy bit and data words, and each result is compared in the order the serial stream produces it.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {OP_EXT = 2'b00, OP_WRITE = 2'b01, OP_READ = 2'b10, OP_ERASE = 2'b11} op_e;
  typedef enum logic [1:0] {SUB_LOCK = 2'b00, SUB_FILL = 2'b01, SUB_WIPE = 2'b10, SUB_UNLOCK = 2'b11} sub_e;
  typedef enum logic [2:0] {PG_NONE, PG_WRITE, PG_ERASE, PG_FILL, PG_WIPE} prog_e;

  // number of address bits in a frame for the chosen organization
  function automatic int abits_f(logic org, int aw16);
    return org ? aw16 : aw16 + 1;
  endfunction

  // number of data bits per word for the chosen organization
  function automatic int dbits_f(logic org, int dw);
    return org ? dw : dw / 2;
  endfunction

  // sequential read pointer: +1, wrapping inside the active address space
  function automatic int next_addr_f(int a, int abits);
    return (a + 1) & ((1 << abits) - 1);
  endfunction
endpackage

// File: rtl/eep_ptimer.sv
module eep_ptimer #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(CYC));
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int WORDS = 64,
  parameter int DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         org,
  input  eep_pkg::prog_e               wr_kind,
  input  logic [$clog2(WORDS):0]       wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [$clog2(WORDS):0]       rd_addr,
  output logic [DW-1:0]                rd_data
);
  import eep_pkg::*;
  localparam int AW16 = $clog2(WORDS);
  localparam int HW   = DW / 2;

  logic [DW-1:0] mem [WORDS];
  logic [AW16-1:0] wwi, rwi;
  logic [DW-1:0] wword;

  // word index and word content a write leaves, for both organizations
  always_comb begin
    wwi   = org ? wr_addr[AW16-1:0] : wr_addr[AW16:1];
    wword = mem[wwi];
    if (wr_kind == PG_ERASE) begin
      if (org) wword = '1;
      else if (wr_addr[0]) wword[HW-1:0] = '1;
      else wword[DW-1:HW] = '1;
    end else begin
      if (org) wword = wr_data;
      else if (wr_addr[0]) wword[HW-1:0] = wr_data[HW-1:0];
      else wword[DW-1:HW] = wr_data[HW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      case (wr_kind)
        PG_WRITE, PG_ERASE: mem[wwi] <= wword;
        PG_FILL:  for (int i = 0; i < WORDS; i++) mem[i] <= org ? wr_data : {2{wr_data[HW-1:0]}};
        PG_WIPE:  for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        default: ;
      endcase
    end
  end

  assign rwi = org ? rd_addr[AW16-1:0] : rd_addr[AW16:1];
  always_comb begin
    if (org) rd_data = mem[rwi];
    else rd_data = {{HW{1'b0}}, rd_addr[0] ? mem[rwi][HW-1:0] : mem[rwi][DW-1:HW]};
  end
endmodule

// File: rtl/eep_frame.sv
module eep_frame #(
  parameter int AW16 = 6,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_s,
  input  logic                 di_s,
  input  logic                 sk_rise,
  input  logic                 cs_fall,
  input  logic                 org,
  input  logic                 hold,
  output logic                 rd_start,
  output logic                 rd_active,
  output logic                 en_set,
  output logic                 en_clr,
  output logic                 go,
  output eep_pkg::prog_e       go_kind,
  output logic [AW16:0]        f_addr,
  output logic [DW-1:0]        f_data
);
  import eep_pkg::*;
  typedef enum logic [2:0] {F_IDLE, F_CMD, F_DATA, F_HOLD, F_READ} fst_e;
  localparam int SRW = AW16 + 3;
  localparam int CW  = $clog2(DW + SRW + 1);

  fst_e st;
  logic [SRW-1:0] sr;
  logic [SRW-1:0] nsr;
  logic [CW-1:0] cnt;
  prog_e kind;
  int abits, dbits;
  op_e op;
  sub_e sub;

  assign abits = abits_f(org, AW16);
  assign dbits = dbits_f(org, DW);
  assign nsr   = {sr[SRW-2:0], di_s};
  assign op    = op_e'(nsr[abits +: 2]);
  assign sub   = sub_e'(nsr[abits - 2 +: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; sr <= '0; cnt <= '0; kind <= PG_NONE;
      f_addr <= '0; f_data <= '0; rd_start <= 1'b0; en_set <= 1'b0; en_clr <= 1'b0;
    end else begin
      rd_start <= 1'b0; en_set <= 1'b0; en_clr <= 1'b0;
      if (!cs_s) begin
        st <= F_IDLE; kind <= PG_NONE;
      end else if (sk_rise) begin
        case (st)
          F_IDLE: if (!hold && di_s) begin
            st <= F_CMD; sr <= '0; cnt <= '0;
          end
          F_CMD: begin
            sr  <= nsr;
            cnt <= cnt + 1'b1;
            if (int'(cnt) + 1 == abits + 2) begin
              f_addr <= (AW16 + 1)'(nsr & SRW'((1 << abits) - 1));
              cnt    <= '0;
              f_data <= '0;
              case (op)
                OP_READ:  begin st <= F_READ; rd_start <= 1'b1; end
                OP_WRITE: begin st <= F_DATA; kind <= PG_WRITE; end
                OP_ERASE: begin st <= F_HOLD; kind <= PG_ERASE; end
                default: case (sub)
                  SUB_UNLOCK: begin st <= F_HOLD; en_set <= 1'b1; end
                  SUB_LOCK:   begin st <= F_HOLD; en_clr <= 1'b1; end
                  SUB_WIPE:   begin st <= F_HOLD; kind <= PG_WIPE; end
                  default:    begin st <= F_DATA; kind <= PG_FILL; end
                endcase
              endcase
            end
          end
          F_DATA: begin
            f_data <= {f_data[DW-2:0], di_s};
            cnt    <= cnt + 1'b1;
            if (int'(cnt) + 1 == dbits) st <= F_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign go        = cs_fall && (st == F_HOLD) && (kind != PG_NONE);
  assign go_kind   = kind;
  assign rd_active = (st == F_READ);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) hold |-> st == F_IDLE);
  // R9
  cs_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |=> st == F_IDLE);
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave #(
  parameter int WORDS       = 64,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);
  import eep_pkg::*;
  localparam int AW16 = $clog2(WORDS);
  localparam int BAW  = AW16 + 1;
  localparam int IW   = $clog2(DW);

  logic cs_s, sk_s, di_s, cs_q, sk_q;
  logic sk_rise, cs_fall;
  logic rd_start, rd_active, en_set, en_clr, go, launch, busy;
  prog_e go_kind, wr_kind;
  logic [BAW-1:0] f_addr, rd_addr;
  logic [DW-1:0] f_data, rd_data;
  logic wen_q, status_q, do_bit;
  logic [IW-1:0] rd_idx;
  int dbits, abits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {cs_s, sk_s, di_s, cs_q, sk_q} <= '0;
    else begin
      cs_s <= cs; sk_s <= sk; di_s <= di;
      cs_q <= cs_s; sk_q <= sk_s;
    end
  end
  assign sk_rise = sk_s & ~sk_q;
  assign cs_fall = cs_q & ~cs_s;

  eep_frame #(.AW16(AW16), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .org(org), .hold(busy | status_q), .rd_start(rd_start),
    .rd_active(rd_active), .en_set(en_set), .en_clr(en_clr), .go(go),
    .go_kind(go_kind), .f_addr(f_addr), .f_data(f_data));

  assign launch  = go & wen_q;
  assign wr_kind = launch ? go_kind : PG_NONE;

  eep_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .org(org), .wr_kind(wr_kind), .wr_addr(f_addr),
    .wr_data(f_data), .rd_addr(rd_addr), .rd_data(rd_data));

  eep_ptimer #(.CYC(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .busy(busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0; status_q <= 1'b0;
    end else begin
      if (en_set) wen_q <= 1'b1;
      else if (en_clr) wen_q <= 1'b0;
      if (launch) status_q <= 1'b1;
      else if (cs_fall && !busy) status_q <= 1'b0;
    end
  end

  assign dbits = dbits_f(org, DW);
  assign abits = abits_f(org, AW16);

  // read stream: dummy 0 first, then bits MSB first, pointer advances per word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0; rd_idx <= '0; do_bit <= 1'b0;
    end else if (!cs_s) begin
      rd_idx <= '0; do_bit <= 1'b0;
    end else if (rd_start) begin
      rd_addr <= f_addr; rd_idx <= '0; do_bit <= 1'b0;
    end else if (rd_active && sk_rise) begin
      do_bit <= rd_data[dbits - 1 - int'(rd_idx)];
      if (int'(rd_idx) == dbits - 1) begin
        rd_idx  <= '0;
        rd_addr <= BAW'(next_addr_f(int'(rd_addr), abits));
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  assign do_o  = status_q ? ~busy : do_bit;
  assign do_oe = cs & (status_q | rd_active);

  // R3
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wen_q));
  // R10
  busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !rd_active);
  // R4
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_active) |-> !do_bit);
  // R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) status_q |-> !rd_active);
endmodule

// File: tb/sim_eep_serial_slave.sv
module sim_eep_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int PCYC = 300;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  typedef struct { logic [15:0] v; int w; string tag; } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  eep_serial_slave #(.PROG_CYCLES(PCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // monitor: compares produced stream items against the expectation queue
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e, a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      chk(e.tag, a.v, e.v);
    end
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic sample();
    return do_oe ? do_o : 1'bx;
  endfunction

  task automatic pulse(logic b, output logic d);
    di = b; waitc(2);
    sk = 1'b1; waitc(2);
    d = sample();
    sk = 1'b0; waitc(2);
  endtask

  task automatic cs_up();   cs = 1'b1; waitc(2); endtask
  task automatic cs_down(); cs = 1'b0; waitc(3); endtask

  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction

  task automatic send_hdr(logic [1:0] op, int addr, output logic last);
    logic d;
    pulse(1'b1, d);
    pulse(op[1], d);
    pulse(op[0], d);
    for (int i = aw() - 1; i >= 0; i--) pulse(addr[i], d);
    last = d;
  endtask

  task automatic send_data(logic [15:0] v);
    logic d;
    for (int i = dw() - 1; i >= 0; i--) pulse(v[i], d);
  endtask

  // extended commands: sub code in the top two address bits
  task automatic ext_cmd(logic [1:0] sub, logic [15:0] v, bit with_data);
    logic d;
    cs_up();
    send_hdr(2'b00, int'(sub) << (aw() - 2), d);
    if (with_data) send_data(v);
    cs_down();
  endtask

  task automatic rd_seq(int addr, int n, logic [15:0] e0, logic [15:0] e1, string tag);
    logic d;
    logic [15:0] w;
    exp_q.push_back('{16'h0, 1, {tag, " dummy"}});
    exp_q.push_back('{e0, dw(), tag});
    if (n > 1) exp_q.push_back('{e1, dw(), tag});
    cs_up();
    send_hdr(2'b10, addr, d);
    act_q.push_back('{{15'h0, d}, 1, tag});
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int i = 0; i < dw(); i++) begin
        pulse(1'b0, d);
        w = {w[14:0], d};
      end
      act_q.push_back('{w, dw(), tag});
    end
    cs_down();
  endtask

  task automatic wait_ready();
    cs_up(); waitc(PCYC + 20); cs_down();
  endtask

  task automatic prog(logic [1:0] op, int addr, logic [15:0] v);
    logic d;
    cs_up();
    send_hdr(op, addr, d);
    if (op == 2'b01) send_data(v);
    cs_down();
  endtask

  initial begin
    logic d;
    waitc(3);
    // R9 reset state
    chk("R9 reset oe", {15'h0, do_oe}, 16'h0);
    rst_n = 1'b1; waitc(2);
    // R12 R4: fresh storage reads all ones, no enable needed
    rd_seq(3, 1, 16'hFFFF, 0, "R12");
    // R3 write while disabled is ignored
    prog(2'b01, 3, 16'h1234);
    cs_up(); chk("R3 no busy", {15'h0, do_oe}, 16'h0); cs_down();
    rd_seq(3, 1, 16'hFFFF, 0, "R3");
    // R2 enable, then write
    ext_cmd(2'b11, 0, 0);
    prog(2'b01, 3, 16'h1234);
    cs_up();
    chk("R8 busy low", {14'h0, do_oe, do_o}, 16'h2);
    // R10 frame sent while busy is ignored
    send_hdr(2'b11, 3, d);
    cs_down();
    cs_up(); waitc(PCYC);
    chk("R8 ready high", {14'h0, do_oe, do_o}, 16'h3);
    // R10 a frame after ready but before cs low is ignored
    send_hdr(2'b11, 3, d);
    cs_down();
    chk("R9 hiz", {15'h0, do_oe}, 16'h0);
    rd_seq(3, 1, 16'h1234, 0, "R10");
    // R5 sequential read wraps 63 -> 0
    prog(2'b01, 63, 16'hBEEF); wait_ready();
    prog(2'b01, 0, 16'h0F0F); wait_ready();
    rd_seq(63, 2, 16'hBEEF, 16'h0F0F, "R5");
    // R1 leading zeros before the start bit
    cs_up(); pulse(1'b0, d); pulse(1'b0, d); cs_down();
    exp_q.push_back('{16'h0, 1, "R1 dummy"});
    exp_q.push_back('{16'h1234, 16, "R1"});
    cs_up(); pulse(1'b0, d); pulse(1'b0, d);
    begin
      logic [15:0] w;
      send_hdr(2'b10, 3, d);
      act_q.push_back('{{15'h0, d}, 1, "R1"});
      w = '0;
      for (int i = 0; i < 16; i++) begin pulse(1'b0, d); w = {w[14:0], d}; end
      act_q.push_back('{w, 16, "R1"});
    end
    cs_down();
    // R6 byte mode mapping: even byte = high half
    org = 1'b0;
    rd_seq(6, 2, 16'h0012, 16'h0034, "R6 bytes");
    prog(2'b01, 7, 16'h00A5); wait_ready();
    rd_seq(127, 2, 16'h00EF, 16'h000F, "R5 byte wrap");
    org = 1'b1;
    rd_seq(3, 1, 16'h12A5, 0, "R6 byte write");
    // R7 erase one word
    prog(2'b11, 3, 0); wait_ready();
    rd_seq(2, 2, 16'hFFFF, 16'hFFFF, "R7 erase");
    // R11 aborted write
    cs_up(); send_hdr(2'b01, 5, d); pulse(1'b0, d); pulse(1'b1, d); cs_down();
    cs_up(); chk("R11 no busy", {15'h0, do_oe}, 16'h0); cs_down();
    rd_seq(5, 1, 16'hFFFF, 0, "R11");
    // R2 fill all, then wipe all
    ext_cmd(2'b01, 16'hC3C3, 1); wait_ready();
    rd_seq(10, 2, 16'hC3C3, 16'hC3C3, "R2 fill");
    ext_cmd(2'b10, 0, 0); wait_ready();
    rd_seq(40, 1, 16'hFFFF, 0, "R7 wipe");
    // R3 disable then write ignored
    ext_cmd(2'b00, 0, 0);
    prog(2'b01, 8, 16'h0000);
    cs_up(); chk("R3 locked", {15'h0, do_oe}, 16'h0); cs_down();
    rd_seq(8, 1, 16'hFFFF, 0, "R3 locked");
    waitc(4);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R4: stream items left actual %0d expected %0d", act_q.size(), exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule